// File: doc/BRIEF.md
# Gated Duration Down-Counter

This block decides how long a tone channel keeps sounding. It holds a small down-counter. A control write sets a reload value and a mode bit. In load mode the counter simply follows the reload value and does not count. In count mode the counter steps down by one on each quarter-frame enable, which arrives at 240 Hz. When it reaches zero it stays there.

A decoded "count is zero" flag comes out of the block. That flag also blocks the step enable of the attached waveform sequencer, so the waveform freezes and the channel goes quiet. The flag is a level that reflects the counter value. It is not a one-cycle terminal pulse.

To play a note for N quarter frames, software first writes N with the mode bit set, which presets the counter. It then writes again with the mode bit clear, which lets the counter run. There is no streaming data path. The control write, the quarter-frame enable and the step enables are plain single-cycle strobes with no back-pressure. A write is accepted in the cycle its strobe is high.

Top module: `dur_gate_counter`

## Requirements
- R1: After reset, `count_o` is 0, `zero_o` is 1, the stored mode is count mode and the stored reload value is 0.
- R2: A write with `cfg_we` high stores `cfg_wdata[W-1:0]` as the reload value and `cfg_wdata[W]` as the mode, where 1 means load mode and 0 means count mode. The stored values take effect at the next rising clock edge.
- R3: While the effective mode is load mode, `count_o` equals the effective reload value one edge later, and `qtr_en` has no effect. The effective mode is the one being written in that cycle, or else the stored one. The effective reload value follows the same rule.
- R4: In count mode, each cycle with `qtr_en` high and a nonzero count lowers `count_o` by exactly one at the next edge.
- R5: In count mode, a cycle with `qtr_en` low leaves `count_o` unchanged.
- R6: In count mode, a zero count stays zero whatever `qtr_en` does.
- R7: `zero_o` is 1 exactly when `count_o` is 0, in the same cycle with no added delay.
- R8: `step_o` equals `step_in` while the count is nonzero and is 0 while the count is zero, combinationally.
- R9: A write whose mode bit is 0 does not reload the counter. `count_o` keeps counting from its current value, and only the stored reload value changes.
- R10: After a load-mode write of N and a switch to count mode, `zero_o` rises after exactly N `qtr_en` pulses, for every N from 0 to 2^W-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_wdata | input | W+1 | Control word: bit W is the mode, bits W-1..0 are the reload value |
| qtr_en | input | 1 | Quarter-frame count enable |
| step_in | input | 1 | Step enable from the waveform timer |
| count_o | output | W | Current counter value |
| zero_o | output | 1 | Counter-is-zero flag |
| step_o | output | 1 | Step enable passed on to the waveform sequencer |

## Verification
The hardest case to reach from the ports is the last part of a long countdown. For large N, the counter only gets there after N quarter-frame pulses. Extra writes must land in the middle of that run, and extra pulses must arrive after zero is reached. The stimulus therefore sweeps every reload value. For each value it presets, switches to count mode and alternates idle cycles with pulses, so every intermediate value is checked. Halfway through, it writes a count-mode word that carries a different reload value. After the count reaches zero, it keeps sending pulses to check that the counter holds at zero.

// File: rtl/dur_pkg.sv
package dur_pkg;
  typedef enum logic {
    DUR_COUNT = 1'b0,
    DUR_LOAD  = 1'b1
  } dur_mode_e;
endpackage

// File: rtl/dur_cfg_reg.sv
module dur_cfg_reg
  import dur_pkg::*;
#(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W:0]   wdata,
  output logic         load_eff_o,
  output logic [W-1:0] reload_eff_o
);
  dur_mode_e     mode_q;
  logic [W-1:0]  reload_q;
  dur_mode_e     mode_w;

  assign mode_w = dur_mode_e'(wdata[W]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= DUR_COUNT;
      reload_q <= '0;
    end else if (we) begin
      mode_q   <= mode_w;
      reload_q <= wdata[W-1:0];
    end
  end

  // a write is seen in the same cycle (transparent load)
  assign load_eff_o   = we ? (mode_w == DUR_LOAD) : (mode_q == DUR_LOAD);
  assign reload_eff_o = we ? wdata[W-1:0] : reload_q;

  // R2
  cfg_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mode_q == $past(mode_w)) && (reload_q == $past(wdata[W-1:0])));

  // R1
  cfg_reset_chk: assert property (@(posedge clk)
    !rst_n |=> (mode_q == DUR_COUNT) && (reload_q == '0));
endmodule

// File: rtl/dur_down_core.sv
module dur_down_core #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] reload_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         is_zero;

  assign is_zero = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)
      cnt_d = reload_i;
    else if (tick_i && !is_zero)
      cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = is_zero;

  // R3
  load_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cnt_q == $past(reload_i));

  // R4
  dec_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && tick_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - ONE);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !tick_i) |=> $stable(cnt_q));

  // R6
  zero_stick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q == '0) |=> cnt_q == '0);
endmodule

// File: rtl/dur_step_gate.sv
module dur_step_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic zero_i,
  input  logic step_i,
  output logic step_o
);
  assign step_o = step_i & ~zero_i;

  // R8
  gate_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_i |-> !step_o);
endmodule

// File: rtl/dur_gate_counter.sv
module dur_gate_counter #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_we,
  input  logic [W:0]   cfg_wdata,
  input  logic         qtr_en,
  input  logic         step_in,
  output logic [W-1:0] count_o,
  output logic         zero_o,
  output logic         step_o
);
  logic         load_eff;
  logic [W-1:0] reload_eff;

  dur_cfg_reg #(.W(W)) cfg_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .we           (cfg_we),
    .wdata        (cfg_wdata),
    .load_eff_o   (load_eff),
    .reload_eff_o (reload_eff)
  );

  dur_down_core #(.W(W)) core_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load_eff),
    .reload_i (reload_eff),
    .tick_i   (qtr_en),
    .cnt_o    (count_o),
    .zero_o   (zero_o)
  );

  dur_step_gate gate_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .zero_i (zero_o),
    .step_i (step_in),
    .step_o (step_o)
  );

  // R7
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_o == (count_o == '0));
endmodule

// File: tb/dur_gate_counter_tb_top.sv
module dur_gate_counter_tb_top;
  localparam int W = 7;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 1'b0;
  logic [W:0]   cfg_wdata = '0;
  logic         qtr_en = 1'b0;
  logic         step_in = 1'b0;
  logic [W-1:0] count_o;
  logic         zero_o;
  logic         step_o;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic         m_mode;
  logic [W-1:0] m_rel;
  logic [W-1:0] m_cnt;

  always #5 clk = ~clk;

  dur_gate_counter #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .qtr_en(qtr_en), .step_in(step_in), .count_o(count_o),
    .zero_o(zero_o), .step_o(step_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check combinational outputs, advance, check count
  task automatic cyc(input string tag, input logic we, input logic [W:0] wd,
                     input logic q, input logic s);
    logic eff_mode;
    logic [W-1:0] eff_rel;
    cfg_we = we; cfg_wdata = wd; qtr_en = q; step_in = s;
    #1;
    chk("R7 zero flag", int'(zero_o), int'(m_cnt == 0));
    chk("R8 step gate", int'(step_o), int'(s && m_cnt != 0));
    eff_mode = we ? wd[W] : m_mode;
    eff_rel  = we ? wd[W-1:0] : m_rel;
    if (eff_mode) m_cnt = eff_rel;
    else if (q && m_cnt != 0) m_cnt = m_cnt - 1;
    if (we) begin m_mode = wd[W]; m_rel = wd[W-1:0]; end
    @(negedge clk);
    chk(tag, int'(count_o), int'(m_cnt));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    m_mode = 1'b0; m_rel = '0; m_cnt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 count", int'(count_o), 0);
    chk("R1 zero", int'(zero_o), 1);
    cyc("R1 idle count mode", 1'b0, '0, 1'b1, 1'b1);

    for (int n = 0; n < (1 << W); n++) begin
      int pulses;
      pulses = 0;
      // R3: load-mode write, qtr_en ignored
      cyc("R3 load", 1'b1, {1'b1, W'(n)}, 1'b1, 1'b1);
      cyc("R3 load hold", 1'b0, '0, 1'b1, 1'b0);
      // R2/R9: switch to count mode, counter not reloaded
      cyc("R9 mode switch", 1'b1, {1'b0, W'(n)}, 1'b0, 1'b1);
      while (m_cnt != 0 && pulses < (1 << W) + 2) begin
        cyc("R5 idle", 1'b0, '0, 1'b0, 1'b1);
        if (pulses == n / 2)
          cyc("R9 count-mode write", 1'b1, {1'b0, ~W'(n)}, 1'b0, 1'b1);
        cyc("R4 decrement", 1'b0, '0, 1'b1, 1'b1);
        pulses++;
      end
      chk("R10 pulses to zero", pulses, n);
      chk("R10 zero raised", int'(zero_o), 1);
      cyc("R6 hold at zero", 1'b0, '0, 1'b1, 1'b1);
      cyc("R6 hold at zero", 1'b0, '0, 1'b1, 1'b0);
    end

    // R2: stored load mode persists without further writes
    cyc("R2 store load", 1'b1, {1'b1, W'(37)}, 1'b0, 1'b0);
    cyc("R2 stored mode", 1'b0, '0, 1'b1, 1'b1);
    cyc("R2 stored mode", 1'b0, '0, 1'b1, 1'b1);
    cyc("R3 load to zero", 1'b1, {1'b1, W'(0)}, 1'b1, 1'b1);
    cyc("R3 load from zero", 1'b1, {1'b1, W'(5)}, 1'b0, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule